// File: doc/BRIEF.md
# Variable-Length Instruction Fetch and Decode Unit

This block steps through a byte-addressed instruction store for a compact 64-bit instruction set in which an instruction is 1, 2, 9 or 10 bytes long. It puts its program counter on the fetch address port and receives, in the same cycle, the ten bytes that start at that address. From those bytes it decodes one instruction. It splits the leading byte into an operation code and a function code, works out the instruction's length, and extracts the register specifiers and the 64-bit little-endian constant. It also produces the address of the following instruction and the destination of a jump or call.

Each cycle in which `step` is high, the program counter moves on to the next instruction. A mode pin chooses how branch destinations are formed. In absolute mode the destination is the constant itself. In relative mode it is the constant, taken as signed, added to the address of the following instruction. An operation code above 0xB raises `bad_op` and the counter does not move. A halt instruction that is stepped on freezes the unit until reset.

Top module: `ifu_fetch_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the program counter loads the parameter `START_ADDR` (default 0x100) and `halted` clears.
- R2: `op_code` is bits 7:4 of the byte at the program counter and `op_func` is bits 3:0 of that byte.
- R3: `ins_len` is 1 for codes 0 (halt), 1 (nop) and 9 (return). It is 2 for codes 2 (conditional move), 6 (ALU), 0xA (push) and 0xB (pop). It is 9 for codes 7 (jump) and 8 (call), and 10 for codes 3, 4 and 5 (the three moves with a constant).
- R4: For codes 2, 3, 4, 5, 6, 0xA and 0xB, `reg_a` is bits 7:4 and `reg_b` is bits 3:0 of the byte at PC+1. For codes 0, 1, 7, 8 and 9 both fields read 0xF.
- R5: `imm_val` is the 8 bytes at PC+2..PC+9 for codes 3, 4 and 5, and the 8 bytes at PC+1..PC+8 for codes 7 and 8, least significant byte first. It is zero for every other code.
- R6: `seq_pc` equals the program counter plus `ins_len`. A step on a valid instruction other than halt loads `seq_pc` into the program counter.
- R7: For codes 7 and 8, `br_dest` equals `imm_val` when `rel_mode` is 0, and `seq_pc + imm_val` modulo 2^64 when `rel_mode` is 1. For other codes it equals `seq_pc`.
- R8: An operation code above 0xB sets `bad_op`, gives `ins_len` 0, and a step leaves the program counter unchanged.
- R9: A step on code 0 keeps the program counter at the halt instruction. From the next cycle `halted` stays high and the program counter stays fixed until reset.
- R10: When `step` is low, the program counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| step | input | 1 | Advance to the next instruction this cycle |
| rel_mode | input | 1 | 1: branch destinations relative to the next instruction |
| fetch_addr | output | 64 | Current program counter, used as the read address |
| fetch_bytes | input | 80 | Bytes at fetch_addr..fetch_addr+9, byte 0 in bits 7:0 |
| op_code | output | 4 | Operation code nibble |
| op_func | output | 4 | Function code nibble |
| reg_a | output | 4 | First register specifier (0xF when absent) |
| reg_b | output | 4 | Second register specifier (0xF when absent) |
| imm_val | output | 64 | Decoded constant or displacement |
| ins_len | output | 4 | Instruction length in bytes (0 when invalid) |
| seq_pc | output | 64 | Address of the following instruction |
| br_dest | output | 64 | Jump or call destination |
| halted | output | 1 | Unit has stopped on a halt instruction |
| bad_op | output | 1 | Operation code above 0xB |

## Verification
The bound checker watches the program counter's sequencing on every cycle. It checks that a step on a valid non-halt instruction lands on the reported next address, that an idle cycle, an invalid code or the halted state leaves the counter alone, and that `halted` never drops without reset. It also checks on every cycle that lengths stay legal and that the register fields read 0xF for forms without a register byte. Only the bench's directed scenarios show that the decoded values are right. These are the exact constant bytes and their order, register nibbles, lengths of every form, and branch destinations in both modes, including a negative relative offset. They depend on concrete program bytes placed in memory.

// File: rtl/ifu_pkg.sv
// Package: shared constants and the per-opcode shape record for the
// instruction fetch unit. Assumes the 16-value operation code space with
// codes 0x0..0xB defined.
package ifu_pkg;

    localparam int BYTE_W     = 8;
    localparam int NIB_W      = 4;
    localparam int IMM_BYTES  = 8;
    localparam int IMM_W      = IMM_BYTES * BYTE_W;
    localparam int MAX_LEN    = 10;
    localparam int LEN_W      = 4;

    localparam logic [NIB_W-1:0] REG_NONE = 4'hF;

    typedef enum logic [NIB_W-1:0] {
        OP_HALT  = 4'h0,
        OP_NOP   = 4'h1,
        OP_CMOV  = 4'h2,
        OP_IRMOV = 4'h3,
        OP_RMMOV = 4'h4,
        OP_MRMOV = 4'h5,
        OP_ALU   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } op_e;

    // Shape of one instruction form, derived from its operation code.
    typedef struct packed {
        logic             legal;      // code is defined
        logic             has_regs;   // register byte at offset 1
        logic             imm_at1;    // constant starts at offset 1
        logic             imm_at2;    // constant starts at offset 2
        logic             is_branch;  // jump or call
        logic             is_stop;    // halt
        logic [LEN_W-1:0] len;        // bytes occupied
    } shape_t;

endpackage

// File: rtl/ifu_shape_decode.sv
// Module: ifu_shape_decode
// Maps an operation code to the shape of its instruction form (length,
// presence of register byte and constant, branch and halt flags).
// Assumes: purely combinational, undefined codes yield legal = 0, len = 0.
module ifu_shape_decode
    import ifu_pkg::*;
(
    input  logic [NIB_W-1:0] op_code,
    output shape_t           shape
);

    // Decode the form table for the incoming code.
    always_comb begin
        shape = '0;
        case (op_code)
            OP_HALT: begin
                shape.legal   = 1'b1;
                shape.is_stop = 1'b1;
                shape.len     = 4'd1;
            end
            OP_NOP, OP_RET: begin
                shape.legal = 1'b1;
                shape.len   = 4'd1;
            end
            OP_CMOV, OP_ALU, OP_PUSH, OP_POP: begin
                shape.legal    = 1'b1;
                shape.has_regs = 1'b1;
                shape.len      = 4'd2;
            end
            OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
                shape.legal    = 1'b1;
                shape.has_regs = 1'b1;
                shape.imm_at2  = 1'b1;
                shape.len      = 4'd10;
            end
            OP_JUMP, OP_CALL: begin
                shape.legal     = 1'b1;
                shape.imm_at1   = 1'b1;
                shape.is_branch = 1'b1;
                shape.len       = 4'd9;
            end
            default: shape = '0;
        endcase
    end

endmodule

// File: rtl/ifu_field_extract.sv
// Module: ifu_field_extract
// Pulls register specifiers and the little-endian 8-byte constant out of
// the fetched byte window according to the instruction shape.
// Assumes: FETCH_BYTES >= 10, byte 0 of the window in bits 7:0.
module ifu_field_extract
    import ifu_pkg::*;
#(
    parameter int FETCH_BYTES = MAX_LEN
) (
    input  logic [FETCH_BYTES*BYTE_W-1:0] window,
    input  shape_t                        shape,
    output logic [NIB_W-1:0]              reg_a,
    output logic [NIB_W-1:0]              reg_b,
    output logic [IMM_W-1:0]              imm_val
);

    localparam int WIN_W = FETCH_BYTES * BYTE_W;

    logic [BYTE_W-1:0] reg_byte;
    logic [IMM_W-1:0]  word_off1;
    logic [IMM_W-1:0]  word_off2;

    assign reg_byte = window[BYTE_W +: BYTE_W];

    // Gather the two candidate constant words, byte by byte.
    for (genvar k = 0; k < IMM_BYTES; k++) begin : g_imm_bytes
        assign word_off1[k*BYTE_W +: BYTE_W] = window[(k+1)*BYTE_W +: BYTE_W];
        assign word_off2[k*BYTE_W +: BYTE_W] = window[(k+2)*BYTE_W +: BYTE_W];
    end

    // Choose register fields, falling back to the no-register code.
    always_comb begin
        if (shape.has_regs) begin
            reg_a = reg_byte[BYTE_W-1 -: NIB_W];
            reg_b = reg_byte[NIB_W-1:0];
        end else begin
            reg_a = REG_NONE;
            reg_b = REG_NONE;
        end
    end

    // Select the constant by its position in the instruction.
    always_comb begin
        if (shape.imm_at2)      imm_val = word_off2;
        else if (shape.imm_at1) imm_val = word_off1;
        else                    imm_val = '0;
    end

    logic unused_tail;
    assign unused_tail = ^window[WIN_W-1 -: BYTE_W];

endmodule

// File: rtl/ifu_target_calc.sv
// Module: ifu_target_calc
// Computes the sequential successor address and the branch destination,
// either absolute or relative to the successor address.
// Assumes: ADDR_W <= 64; arithmetic wraps modulo 2^ADDR_W.
module ifu_target_calc
    import ifu_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] pc,
    input  shape_t            shape,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              rel_mode,
    output logic [ADDR_W-1:0] seq_pc,
    output logic [ADDR_W-1:0] br_dest
);

    logic [ADDR_W-1:0] imm_addr;

    assign imm_addr = imm_val[ADDR_W-1:0];

    // Successor address from the form length.
    always_comb begin
        seq_pc = pc + ADDR_W'(shape.len);
    end

    // Branch destination in the selected addressing mode.
    always_comb begin
        if (!shape.is_branch) br_dest = seq_pc;
        else if (rel_mode)    br_dest = seq_pc + imm_addr;
        else                  br_dest = imm_addr;
    end

endmodule

// File: rtl/ifu_pc_ctrl.sv
// Module: ifu_pc_ctrl
// Holds the program counter and the halted state. Advances on a step
// over a legal, non-halt instruction; a step on halt latches halted.
// Assumes: synchronous active-low reset.
module ifu_pc_ctrl
    import ifu_pkg::*;
#(
    parameter int                ADDR_W     = 64,
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  shape_t            shape,
    input  logic [ADDR_W-1:0] seq_pc,
    output logic [ADDR_W-1:0] pc,
    output logic              halted
);

    logic may_move;

    assign may_move = step && !halted && shape.legal;

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pc <= START_ADDR;
        else if (may_move && !shape.is_stop) pc <= seq_pc;
    end

    // Halted flag, sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                        halted <= 1'b0;
        else if (may_move && shape.is_stop) halted <= 1'b1;
    end

endmodule

// File: rtl/ifu_fetch_unit.sv
// Module: ifu_fetch_unit
// Top of the variable-length instruction fetch unit: presents the PC as
// the fetch address, decodes the returned byte window and steps the PC.
// Assumes: the instruction store returns FETCH_BYTES bytes combinationally.
module ifu_fetch_unit
    import ifu_pkg::*;
#(
    parameter int                ADDR_W      = 64,
    parameter logic [ADDR_W-1:0] START_ADDR  = 64'h100,
    parameter int                FETCH_BYTES = MAX_LEN
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          step,
    input  logic                          rel_mode,
    output logic [ADDR_W-1:0]             fetch_addr,
    input  logic [FETCH_BYTES*BYTE_W-1:0] fetch_bytes,
    output logic [NIB_W-1:0]              op_code,
    output logic [NIB_W-1:0]              op_func,
    output logic [NIB_W-1:0]              reg_a,
    output logic [NIB_W-1:0]              reg_b,
    output logic [IMM_W-1:0]              imm_val,
    output logic [LEN_W-1:0]              ins_len,
    output logic [ADDR_W-1:0]             seq_pc,
    output logic [ADDR_W-1:0]             br_dest,
    output logic                          halted,
    output logic                          bad_op
);

    shape_t            shape;
    logic [ADDR_W-1:0] pc;

    assign op_code    = fetch_bytes[BYTE_W-1 -: NIB_W];
    assign op_func    = fetch_bytes[NIB_W-1:0];
    assign fetch_addr = pc;
    assign ins_len    = shape.len;
    assign bad_op     = !shape.legal;

    ifu_shape_decode u_shape (
        .op_code (op_code),
        .shape   (shape)
    );

    ifu_field_extract #(.FETCH_BYTES(FETCH_BYTES)) u_fields (
        .window  (fetch_bytes),
        .shape   (shape),
        .reg_a   (reg_a),
        .reg_b   (reg_b),
        .imm_val (imm_val)
    );

    ifu_target_calc #(.ADDR_W(ADDR_W)) u_target (
        .pc       (pc),
        .shape    (shape),
        .imm_val  (imm_val),
        .rel_mode (rel_mode),
        .seq_pc   (seq_pc),
        .br_dest  (br_dest)
    );

    ifu_pc_ctrl #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .shape  (shape),
        .seq_pc (seq_pc),
        .pc     (pc),
        .halted (halted)
    );

endmodule

// File: rtl/ifu_fetch_unit_checker.sv
// Module: ifu_fetch_unit_checker
// Temporal checks on PC sequencing, halt stickiness and field legality,
// bound to every ifu_fetch_unit instance.
module ifu_fetch_unit_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [3:0]        op_code,
    input logic [3:0]        reg_a,
    input logic [3:0]        reg_b,
    input logic [3:0]        ins_len,
    input logic [ADDR_W-1:0] seq_pc,
    input logic              halted,
    input logic              bad_op
);

    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_freezes_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(fetch_addr));

    assert_bad_op_holds_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |=> $stable(fetch_addr));

    assert_idle_holds_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(fetch_addr));

    assert_step_advances_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !halted && !bad_op && op_code != 4'h0) |=> fetch_addr == $past(seq_pc));

    assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_op |-> (ins_len == 4'd1 || ins_len == 4'd2 || ins_len == 4'd9 || ins_len == 4'd10));

    assert_noreg_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'h0 || op_code == 4'h1 || op_code == 4'h7 || op_code == 4'h8 || op_code == 4'h9)
        |-> (reg_a == 4'hF && reg_b == 4'hF));

endmodule

bind ifu_fetch_unit ifu_fetch_unit_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .fetch_addr (fetch_addr),
    .op_code    (op_code),
    .reg_a      (reg_a),
    .reg_b      (reg_b),
    .ins_len    (ins_len),
    .seq_pc     (seq_pc),
    .halted     (halted),
    .bad_op     (bad_op)
);

// File: tb/ifu_fetch_unit_bench.sv
// Directed bench for ifu_fetch_unit: one task per scenario.
module ifu_fetch_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic        rel_mode = 1'b0;
    logic [63:0] fetch_addr;
    logic [79:0] fetch_bytes;
    logic [3:0]  op_code, op_func, reg_a, reg_b, ins_len;
    logic [63:0] imm_val, seq_pc, br_dest;
    logic        halted, bad_op;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0] mem [0:1023];

    always #5 clk = ~clk;

    // Combinational instruction store: ten bytes from the fetch address.
    always_comb begin
        for (int i = 0; i < 10; i++)
            fetch_bytes[i*8 +: 8] = mem[10'(fetch_addr[9:0] + 10'(i))];
    end

    ifu_fetch_unit u_ifu_fetch_unit (
        .clk, .rst_n, .step, .rel_mode, .fetch_addr, .fetch_bytes,
        .op_code, .op_func, .reg_a, .reg_b, .imm_val, .ins_len,
        .seq_pc, .br_dest, .halted, .bad_op
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    endtask

    task automatic put(input int addr, input logic [7:0] b);
        mem[addr[9:0]] = b;
    endtask

    task automatic put_word(input int addr, input logic [63:0] w);
        for (int i = 0; i < 8; i++) put(addr + i, w[i*8 +: 8]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_step();
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    // Check the decode of the instruction at the PC, then step over it.
    task automatic insn(input logic [3:0] ic, input logic [3:0] fn,
                        input logic [3:0] ra, input logic [3:0] rb,
                        input logic [3:0] len, input logic [63:0] cv,
                        input logic [63:0] dest);
        logic [63:0] here;
        here = fetch_addr;
        chk("R2", "op_code", 64'(op_code), 64'(ic));
        chk("R2", "op_func", 64'(op_func), 64'(fn));
        chk("R4", "reg_a", 64'(reg_a), 64'(ra));
        chk("R4", "reg_b", 64'(reg_b), 64'(rb));
        chk("R3", "ins_len", 64'(ins_len), 64'(len));
        chk("R5", "imm_val", imm_val, cv);
        chk("R6", "seq_pc", seq_pc, here + 64'(len));
        chk("R7", "br_dest", br_dest, dest);
        do_step();
        chk("R6", "pc after step", fetch_addr, here + 64'(len));
    endtask

    task automatic t_reset();
        clear_mem();
        put(16'h100, 8'h10);
        do_reset();
        chk("R1", "reset pc", fetch_addr, 64'h100);
        chk("R1", "reset halted", 64'(halted), 64'h0);
    endtask

    task automatic t_idle();
        repeat (3) @(negedge clk);
        chk("R10", "pc without step", fetch_addr, 64'h100);
    endtask

    task automatic t_program();
        clear_mem();
        put(16'h100, 8'h30); put(16'h101, 8'hF2); put_word(16'h102, 64'hABCD);
        put(16'h10A, 8'h60); put(16'h10B, 8'h06);
        put(16'h10C, 8'h40); put(16'h10D, 8'h64); put_word(16'h10E, 64'h41C);
        put(16'h116, 8'h50); put(16'h117, 8'h31); put_word(16'h118, 64'h1122334455667788);
        put(16'h120, 8'h25); put(16'h121, 8'h12);
        put(16'h122, 8'hA0); put(16'h123, 8'h7F);
        put(16'h124, 8'hB0); put(16'h125, 8'h8F);
        put(16'h126, 8'h10);
        put(16'h127, 8'h73); put_word(16'h128, 64'h200);
        put(16'h130, 8'h80); put_word(16'h131, 64'h300);
        put(16'h139, 8'h90);
        put(16'h13A, 8'h00);
        rel_mode = 1'b0;
        do_reset();
        insn(4'h3, 4'h0, 4'hF, 4'h2, 4'd10, 64'hABCD, 64'h10A);
        insn(4'h6, 4'h0, 4'h0, 4'h6, 4'd2, 64'h0, 64'h10C);
        insn(4'h4, 4'h0, 4'h6, 4'h4, 4'd10, 64'h41C, 64'h116);
        insn(4'h5, 4'h0, 4'h3, 4'h1, 4'd10, 64'h1122334455667788, 64'h120);
        insn(4'h2, 4'h5, 4'h1, 4'h2, 4'd2, 64'h0, 64'h122);
        insn(4'hA, 4'h0, 4'h7, 4'hF, 4'd2, 64'h0, 64'h124);
        insn(4'hB, 4'h0, 4'h8, 4'hF, 4'd2, 64'h0, 64'h126);
        insn(4'h1, 4'h0, 4'hF, 4'hF, 4'd1, 64'h0, 64'h127);
        insn(4'h7, 4'h3, 4'hF, 4'hF, 4'd9, 64'h200, 64'h200);
        insn(4'h8, 4'h0, 4'hF, 4'hF, 4'd9, 64'h300, 64'h300);
        insn(4'h9, 4'h0, 4'hF, 4'hF, 4'd1, 64'h0, 64'h13A);
    endtask

    // Continues from t_program: PC sits on the halt byte at 0x13A.
    task automatic t_halt();
        chk("R9", "halt len", 64'(ins_len), 64'd1);
        do_step();
        chk("R9", "halted set", 64'(halted), 64'h1);
        chk("R9", "pc on halt", fetch_addr, 64'h13A);
        put(16'h13A, 8'h10);
        repeat (3) do_step();
        chk("R9", "pc frozen", fetch_addr, 64'h13A);
        chk("R9", "still halted", 64'(halted), 64'h1);
        do_reset();
        chk("R1", "pc after re-reset", fetch_addr, 64'h100);
        chk("R1", "halted cleared", 64'(halted), 64'h0);
    endtask

    task automatic t_relative();
        clear_mem();
        put(16'h100, 8'h80); put_word(16'h101, 64'hF7);
        put(16'h109, 8'h70); put_word(16'h10A, 64'hFFFF_FFFF_FFFF_FF80);
        rel_mode = 1'b1;
        do_reset();
        insn(4'h8, 4'h0, 4'hF, 4'hF, 4'd9, 64'hF7, 64'h200);
        chk("R7", "negative rel dest", br_dest, 64'h92);
        rel_mode = 1'b0;
        @(negedge clk);
        chk("R7", "absolute dest", br_dest, 64'hFFFF_FFFF_FFFF_FF80);
        insn(4'h7, 4'h0, 4'hF, 4'hF, 4'd9, 64'hFFFF_FFFF_FFFF_FF80, 64'hFFFF_FFFF_FFFF_FF80);
    endtask

    task automatic t_invalid();
        clear_mem();
        put(16'h100, 8'hC4);
        do_reset();
        chk("R8", "bad_op set", 64'(bad_op), 64'h1);
        chk("R8", "len zero", 64'(ins_len), 64'h0);
        do_step();
        chk("R8", "pc held", fetch_addr, 64'h100);
        put(16'h100, 8'hB0);
        @(negedge clk);
        chk("R8", "code B is legal", 64'(bad_op), 64'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        t_reset();
        t_idle();
        t_program();
        t_halt();
        t_relative();
        t_invalid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule